// File: doc/BRIEF.md
# Channelised HDLC Frame Status Checker

This block sits behind a multichannel HDLC deframer that has already found the flags and removed the stuffed zero bits. Each cycle it may receive one frame byte tagged with a connection number. The bytes of many connections can arrive interleaved in any order. For every connection the block keeps a running frame check sequence and a byte count in a small state memory. When a frame ends, it writes one 32-bit status word for the capture record. The word holds the connection number and one flag for each detected problem: a bad FCS, a short frame, a long frame, an abort, and a frame whose length is not a whole number of bytes.

A byte is accepted when `in_valid` is high. If `in_last` is also high, that byte is the final byte of the frame, and it counts toward the length and the FCS. In that cycle `in_bits` gives how many bits of a trailing partial byte were left over. If `in_abort` is high, the frame is closed as aborted, and the byte on that cycle is discarded. The check mode `fcs_mode` is expected to stay constant while any frame is open.

Top module: `hdlc_chan_status`

## Requirements
- R1: Each accepted byte with `in_last` or `in_abort` high produces exactly one `hdr_valid` pulse two clock edges later. `hdr_valid` is never high at any other time.
- R2: Bits 9:0 of `hdr_word` hold the connection number of the frame that ended.
- R3: Bits 23:10 and 31:29 of `hdr_word` are always zero.
- R4: Bit 24 flags an FCS error. `fcs_mode` 1 selects CRC-16 (reflected polynomial 0x8408, preset 0xFFFF, good residue 0xF0B8). `fcs_mode` 2 selects CRC-32 (reflected polynomial 0xEDB88320, preset 0xFFFFFFFF, good residue 0xDEBB20E3). In both modes the check runs over every byte of the frame including the FCS, and the FCS is sent complemented, low byte first. With `fcs_mode` 0 or 3, bit 24 is never set.
- R5: Bit 25 is set when the frame held fewer than 5 bytes. The count includes the FCS bytes and the final byte, so a frame of exactly 5 bytes is not short.
- R6: Bit 26 is set when the frame held more than 2047 bytes. The count saturates, so a frame of any greater length still reports long, and a frame of exactly 2047 bytes does not.
- R7: An abort byte ends the frame with only bit 27 and the connection number set, whatever the bytes already received.
- R8: Bit 28 is set when `in_bits` is nonzero on the final byte of a frame that was not aborted.
- R9: Connections are independent. Bytes of different connections may interleave freely, and bytes of the same connection may arrive on consecutive cycles, without affecting any other frame's result.
- R10: After reset, and after any frame ends (normally or by abort), the next byte on that connection starts a fresh frame.
- R11: While reset is high, `hdr_valid` and `hdr_word` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte is present this cycle |
| in_conn | input | 10 | Connection number of the byte |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Byte is the final byte of its frame |
| in_abort | input | 1 | Frame is aborted; byte discarded |
| in_bits | input | 3 | Leftover bit count after the final byte (0 = aligned) |
| fcs_mode | input | 2 | 0/3 off, 1 CRC-16, 2 CRC-32 |
| hdr_valid | output | 1 | Status word valid for one cycle |
| hdr_word | output | 32 | Multichannel status word |

## Verification
The bench builds the block with 16 connections and the default length limits of 5 and 2047 bytes. The small state memory means randomly interleaved traffic on 4 or 16 connections often lands on the same connection in consecutive cycles, which exercises the one-cycle write bypass. Keeping the real 2047-byte limit lets directed frames of 2047, 2048 and 3004 bytes probe the long-frame boundary and the saturating count. Directed frames of 4 and 5 bytes cover the short-frame edge.

// File: rtl/hdlc_chk_pkg.sv
package hdlc_chk_pkg;

  typedef enum logic [1:0] {
    FCS_OFF   = 2'd0,
    FCS_CRC16 = 2'd1,
    FCS_CRC32 = 2'd2,
    FCS_OFF2  = 2'd3
  } fcs_mode_e;

  // status word bit positions
  localparam int HB_FCS   = 24;
  localparam int HB_SHORT = 25;
  localparam int HB_LONG  = 26;
  localparam int HB_ABORT = 27;
  localparam int HB_OCTET = 28;

  localparam logic [15:0] POLY16 = 16'h8408;
  localparam logic [31:0] POLY32 = 32'hEDB88320;
  localparam logic [15:0] RES16  = 16'hF0B8;
  localparam logic [31:0] RES32  = 32'hDEBB20E3;

  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ POLY16) : (r >> 1);
    return r;
  endfunction

  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ POLY32) : (r >> 1);
    return r;
  endfunction

endpackage

// File: rtl/hdlc_state_ram.sv
module hdlc_state_ram #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 44,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/hdlc_fcs_unit.sv
module hdlc_fcs_unit
  import hdlc_chk_pkg::*;
(
  input  logic [1:0]  mode,
  input  logic [31:0] crc_in,
  input  logic [7:0]  data,
  output logic [31:0] crc_out,
  output logic        fcs_bad
);

  always_comb begin
    case (fcs_mode_e'(mode))
      FCS_CRC16: begin
        crc_out = {crc_in[31:16], crc16_byte(crc_in[15:0], data)};
        fcs_bad = (crc_out[15:0] != RES16);
      end
      FCS_CRC32: begin
        crc_out = crc32_byte(crc_in, data);
        fcs_bad = (crc_out != RES32);
      end
      default: begin
        crc_out = crc_in;
        fcs_bad = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/hdlc_hdr_pack.sv
module hdlc_hdr_pack
  import hdlc_chk_pkg::*;
#(
  parameter int CONN_W = 10
) (
  input  logic [CONN_W-1:0] conn,
  input  logic              aborted,
  input  logic              fcs_bad,
  input  logic              too_short,
  input  logic              too_long,
  input  logic              octet_err,
  output logic [31:0]       word
);

  always_comb begin
    word = '0;
    word[CONN_W-1:0] = conn;
    if (aborted) begin
      word[HB_ABORT] = 1'b1;
    end else begin
      word[HB_FCS]   = fcs_bad;
      word[HB_SHORT] = too_short;
      word[HB_LONG]  = too_long;
      word[HB_OCTET] = octet_err;
    end
  end

endmodule

// File: rtl/hdlc_chan_status.sv
module hdlc_chan_status #(
  parameter int CONN_W   = 10,
  parameter int NUM_CONN = 512,
  parameter int MIN_LEN  = 5,
  parameter int MAX_LEN  = 2047
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CONN_W-1:0] in_conn,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic              in_abort,
  input  logic [2:0]        in_bits,
  input  logic [1:0]        fcs_mode,
  output logic              hdr_valid,
  output logic [31:0]       hdr_word
);

  localparam int ADDR_W = $clog2(NUM_CONN);
  localparam int CNT_W  = $clog2(MAX_LEN + 2);
  localparam int ST_W   = 32 + CNT_W;
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_LEN + 1);
  localparam logic [ST_W-1:0]  FRESH   = {32'hFFFF_FFFF, {CNT_W{1'b0}}};

  // stage 1: registered byte alongside the synchronous state read
  logic              s1_v, s1_last, s1_abort;
  logic [CONN_W-1:0] s1_conn;
  logic [7:0]        s1_data;
  logic [2:0]        s1_bits;
  logic [1:0]        s1_mode;

  always_ff @(posedge clk) begin
    if (rst) s1_v <= 1'b0;
    else     s1_v <= in_valid;
    s1_conn  <= in_conn;
    s1_data  <= in_data;
    s1_last  <= in_last;
    s1_abort <= in_abort;
    s1_bits  <= in_bits;
    s1_mode  <= fcs_mode;
  end

  logic [ADDR_W-1:0] s1_addr;
  logic              s1_end;
  assign s1_addr = s1_conn[ADDR_W-1:0];
  assign s1_end  = s1_v && (s1_last || s1_abort);

  // per-connection running state
  logic              ram_we;
  logic [ST_W-1:0]   rd_state, nxt_state;

  hdlc_state_ram #(.DEPTH(NUM_CONN), .WIDTH(ST_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (s1_addr),
    .wdata (nxt_state),
    .raddr (in_conn[ADDR_W-1:0]),
    .rdata (rd_state)
  );

  // bypass for a write that landed on the same edge as the read
  logic              wb_v;
  logic [ADDR_W-1:0] wb_addr;
  logic [ST_W-1:0]   wb_state;

  always_ff @(posedge clk) begin
    if (rst) wb_v <= 1'b0;
    else     wb_v <= ram_we;
    wb_addr  <= s1_addr;
    wb_state <= nxt_state;
  end

  // open-frame flags, cleared by reset so memory needs no initialisation
  logic [NUM_CONN-1:0] open_q;

  always_ff @(posedge clk) begin
    if (rst)       open_q <= '0;
    else if (s1_v) open_q[s1_addr] <= !s1_end;
  end

  logic [ST_W-1:0]  cur_state;
  logic [31:0]      cur_crc, nxt_crc;
  logic [CNT_W-1:0] cur_cnt, nxt_cnt;
  logic             fcs_bad;

  always_comb begin
    if (!open_q[s1_addr])                cur_state = FRESH;
    else if (wb_v && wb_addr == s1_addr) cur_state = wb_state;
    else                                 cur_state = rd_state;
  end

  assign cur_crc = cur_state[ST_W-1:CNT_W];
  assign cur_cnt = cur_state[CNT_W-1:0];
  assign nxt_cnt = (cur_cnt == CNT_SAT) ? CNT_SAT : cur_cnt + 1'b1;

  hdlc_fcs_unit u_fcs (
    .mode    (s1_mode),
    .crc_in  (cur_crc),
    .data    (s1_data),
    .crc_out (nxt_crc),
    .fcs_bad (fcs_bad)
  );

  assign nxt_state = {nxt_crc, nxt_cnt};
  assign ram_we    = s1_v && !s1_end;

  logic [31:0] hdr_next;

  hdlc_hdr_pack #(.CONN_W(CONN_W)) u_pack (
    .conn      (s1_conn),
    .aborted   (s1_abort),
    .fcs_bad   (fcs_bad),
    .too_short (nxt_cnt < CNT_W'(MIN_LEN)),
    .too_long  (nxt_cnt > CNT_W'(MAX_LEN)),
    .octet_err (s1_bits != 3'd0),
    .word      (hdr_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_valid <= 1'b0;
      hdr_word  <= '0;
    end else begin
      hdr_valid <= s1_end;
      if (s1_end) hdr_word <= hdr_next;
    end
  end

endmodule

// File: rtl/hdlc_chan_status_chk.sv
module hdlc_chan_status_chk #(
  parameter int CONN_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [CONN_W-1:0] in_conn,
  input logic              in_last,
  input logic              in_abort,
  input logic [2:0]        in_bits,
  input logic [1:0]        fcs_mode,
  input logic              hdr_valid,
  input logic [31:0]       hdr_word
);

  logic frame_end;
  assign frame_end = in_valid && (in_last || in_abort);

  assert_hdr_follows_end_R1: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> ##1 hdr_valid);

  assert_no_spurious_hdr_R1: assert property (@(posedge clk) disable iff (rst)
    hdr_valid |-> $past(frame_end, 2));

  assert_conn_field_R2: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> ##1 (hdr_word[9:0] == 10'($past(in_conn, 2))));

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (rst)
    hdr_valid |-> (hdr_word[23:10] == '0 && hdr_word[31:29] == '0));

  assert_fcs_off_clean_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_last && !in_abort && (fcs_mode == 2'd0 || fcs_mode == 2'd3))
      |=> ##1 !hdr_word[24]);

  assert_abort_only_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_abort) |=> ##1 (hdr_word[27] && hdr_word[26:24] == 3'b000 && !hdr_word[28]));

  assert_octet_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_last && !in_abort && in_bits != 3'd0) |=> ##1 hdr_word[28]);

endmodule

bind hdlc_chan_status hdlc_chan_status_chk #(.CONN_W(CONN_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_conn   (in_conn),
  .in_last   (in_last),
  .in_abort  (in_abort),
  .in_bits   (in_bits),
  .fcs_mode  (fcs_mode),
  .hdr_valid (hdr_valid),
  .hdr_word  (hdr_word)
);

// File: tb/tb_hdlc_chan_status.sv
module tb_hdlc_chan_status;

  localparam int CONN_W   = 10;
  localparam int NUM_CONN = 16;
  localparam int SLOT_B   = 48;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [CONN_W-1:0] in_conn = '0;
  logic [7:0]        in_data = '0;
  logic              in_last = 1'b0;
  logic              in_abort = 1'b0;
  logic [2:0]        in_bits = '0;
  logic [1:0]        fcs_mode = 2'd1;
  logic              hdr_valid;
  logic [31:0]       hdr_word;

  hdlc_chan_status #(.CONN_W(CONN_W), .NUM_CONN(NUM_CONN), .MIN_LEN(5), .MAX_LEN(2047)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_conn(in_conn), .in_data(in_data),
    .in_last(in_last), .in_abort(in_abort), .in_bits(in_bits), .fcs_mode(fcs_mode),
    .hdr_valid(hdr_valid), .hdr_word(hdr_word)
  );

  always #5ns clk = ~clk;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  int          due_q[$];
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  // ---- reference functions built from the requirements ----
  function automatic logic [15:0] ref_crc16(logic [15:0] c, logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = c[0] ^ d[i];
      c = c >> 1;
      if (fb) c = c ^ 16'h8408;
    end
    return c;
  endfunction

  function automatic logic [31:0] ref_crc32(logic [31:0] c, logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = c[0] ^ d[i];
      c = c >> 1;
      if (fb) c = c ^ 32'hEDB88320;
    end
    return c;
  endfunction

  function automatic logic [31:0] exp_word(int conn, int n, bit bad, int bits, bit ab);
    logic [31:0] w;
    w = 32'(conn) & 32'h3FF;
    if (ab) w[27] = 1'b1;
    else begin
      w[24] = bad;
      w[25] = (n < 5);
      w[26] = (n > 2047);
      w[28] = (bits != 0);
    end
    return w;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  // ---- output monitor ----
  always @(negedge clk) begin
    if (!finished && cyc > 0) begin
      if (rst) begin
        chk(hdr_valid == 1'b0 && hdr_word == 32'h0, "R11", "reset outputs", {hdr_valid, hdr_word[30:0]}, 32'h0);
      end else if (due_q.size() > 0 && due_q[0] == cyc) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        void'(due_q.pop_front());
        chk(hdr_valid == 1'b1, "R1", {"header missing ", t}, 32'(hdr_valid), 32'h1);
        if (hdr_valid) begin
          chk(hdr_word[9:0] == e[9:0], "R2", {"conn field ", t}, hdr_word, e);
          chk(hdr_word[23:10] == 14'h0 && hdr_word[31:29] == 3'h0, "R3", {"reserved ", t}, hdr_word, e);
          chk(hdr_word[24] == e[24], "R4", {"fcs bit ", t}, hdr_word, e);
          chk(hdr_word[25] == e[25], "R5", {"short bit ", t}, hdr_word, e);
          chk(hdr_word[26] == e[26], "R6", {"long bit ", t}, hdr_word, e);
          chk(hdr_word[27] == e[27], "R7", {"abort bit ", t}, hdr_word, e);
          chk(hdr_word[28] == e[28], "R8", {"octet bit ", t}, hdr_word, e);
        end
      end else begin
        chk(hdr_valid == 1'b0, "R1", "unexpected header", 32'(hdr_valid), 32'h0);
      end
    end
  end

  // ---- drivers ----
  task automatic drive(int conn, logic [7:0] d, bit last, bit ab, int bits);
    @(negedge clk);
    in_valid = 1'b1;
    in_conn  = CONN_W'(conn);
    in_data  = d;
    in_last  = last;
    in_abort = ab;
    in_bits  = 3'(bits);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    in_abort = 1'b0;
    in_bits  = '0;
  endtask

  task automatic push_exp(logic [31:0] w, string tag);
    due_q.push_back(cyc + 2);
    exp_q.push_back(w);
    tag_q.push_back(tag);
  endtask

  // stream one frame of plen payload bytes plus FCS, optionally corrupting the first byte sent
  task automatic send_stream(int conn, int plen, int mode, bit corrupt, int bits, string tag);
    logic [15:0] c16 = 16'hFFFF;
    logic [31:0] c32 = 32'hFFFF_FFFF;
    int flen = (mode == 1) ? 2 : (mode == 2) ? 4 : 0;
    int n = plen + flen;
    logic [31:0] fcs;
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      if (i < plen) begin
        b = 8'($urandom);
        c16 = ref_crc16(c16, b);
        c32 = ref_crc32(c32, b);
      end else begin
        fcs = (mode == 1) ? {16'h0, ~c16} : ~c32;
        b = fcs[8*(i-plen) +: 8];
      end
      if (corrupt && i == 0) b = b ^ 8'h5A;
      drive(conn, b, i == n - 1, 1'b0, (i == n - 1) ? bits : 0);
      if (i == n - 1) push_exp(exp_word(conn, n, corrupt && (mode == 1 || mode == 2), bits, 1'b0), tag);
    end
    idle();
  endtask

  task automatic send_abort(int conn, int nbytes, string tag);
    for (int i = 0; i < nbytes; i++) drive(conn, 8'($urandom), 1'b0, 1'b0, 0);
    drive(conn, 8'($urandom), 1'b0, 1'b1, 0);
    push_exp(exp_word(conn, 0, 1'b0, 0, 1'b1), tag);
    idle();
  endtask

  // ---- interleaved random traffic ----
  logic [7:0] rb [NUM_CONN][SLOT_B];
  int  rlen [NUM_CONN];
  int  rpos [NUM_CONN];
  int  rcut [NUM_CONN];
  int  rbits[NUM_CONN];
  bit  rbad [NUM_CONN];
  bit  rab  [NUM_CONN];
  bit  ract [NUM_CONN];

  task automatic build_slot(int s, int mode);
    logic [15:0] c16 = 16'hFFFF;
    logic [31:0] c32 = 32'hFFFF_FFFF;
    int plen = $urandom_range(40, (mode == 1 || mode == 2) ? 0 : 1);
    int flen = (mode == 1) ? 2 : (mode == 2) ? 4 : 0;
    logic [31:0] fcs;
    for (int i = 0; i < plen; i++) begin
      rb[s][i] = 8'($urandom);
      c16 = ref_crc16(c16, rb[s][i]);
      c32 = ref_crc32(c32, rb[s][i]);
    end
    fcs = (mode == 1) ? {16'h0, ~c16} : ~c32;
    for (int i = 0; i < flen; i++) rb[s][plen + i] = fcs[8*i +: 8];
    rlen[s] = plen + flen;
    rbad[s] = ($urandom_range(3, 0) == 0);
    if (rbad[s]) begin
      int p = $urandom_range(rlen[s] - 1, 0);
      rb[s][p] = rb[s][p] ^ 8'($urandom_range(255, 1));
    end
    rab[s]   = ($urandom_range(7, 0) == 0);
    rcut[s]  = $urandom_range(rlen[s] - 1, 0);
    rbits[s] = ($urandom_range(7, 0) == 0) ? $urandom_range(7, 1) : 0;
    rpos[s]  = 0;
    ract[s]  = 1'b1;
  endtask

  task automatic run_random(int mode, int nslots, int nframes);
    int done_frames = 0;
    for (int s = 0; s < NUM_CONN; s++) ract[s] = 1'b0;
    fcs_mode = 2'(mode);
    while (done_frames < nframes) begin
      int s = $urandom_range(nslots - 1, 0);
      if (!ract[s]) build_slot(s, mode);
      if ($urandom_range(3, 0) == 0) idle();
      if (rab[s] && rpos[s] == rcut[s]) begin
        drive(s, 8'($urandom), 1'b0, 1'b1, 0);
        push_exp(exp_word(s, 0, 1'b0, 0, 1'b1), "R9 random abort");
        ract[s] = 1'b0;
        done_frames++;
      end else if (rpos[s] == rlen[s] - 1) begin
        drive(s, rb[s][rpos[s]], 1'b1, 1'b0, rbits[s]);
        push_exp(exp_word(s, rlen[s], rbad[s] && (mode == 1 || mode == 2), rbits[s], 1'b0), "R9 random");
        ract[s] = 1'b0;
        done_frames++;
      end else begin
        drive(s, rb[s][rpos[s]], 1'b0, 1'b0, 0);
        rpos[s]++;
      end
    end
    // close any frames still open by aborting them
    for (int s = 0; s < nslots; s++) begin
      if (ract[s]) begin
        drive(s, 8'h00, 1'b0, 1'b1, 0);
        push_exp(exp_word(s, 0, 1'b0, 0, 1'b1), "R9 cleanup abort");
        ract[s] = 1'b0;
      end
    end
    idle();
  endtask

  // ---- main sequence ----
  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    idle();

    // R4: CRC-16 good and corrupt, CRC-32 good and corrupt, check off
    fcs_mode = 2'd1;
    send_stream(9, 4, 1, 1'b0, 0, "R4 crc16 good");
    send_stream(9, 7, 1, 1'b1, 0, "R4 crc16 corrupt");
    fcs_mode = 2'd2;
    send_stream(300, 10, 2, 1'b0, 0, "R4 crc32 good");
    send_stream(301, 10, 2, 1'b1, 0, "R4 crc32 corrupt");
    fcs_mode = 2'd0;
    send_stream(12, 9, 0, 1'b1, 0, "R4 check off");
    fcs_mode = 2'd3;
    send_stream(12, 9, 0, 1'b0, 0, "R4 check off alt");

    // R5: 4-byte frame is short, 5-byte frame is not
    fcs_mode = 2'd1;
    send_stream(3, 2, 1, 1'b0, 0, "R5 four bytes");
    send_stream(3, 3, 1, 1'b0, 0, "R5 five bytes");
    fcs_mode = 2'd0;
    send_stream(4, 1, 0, 1'b0, 0, "R5 single byte");

    // R6: 2047 not long, 2048 long, 3004 long with saturated count
    fcs_mode = 2'd1;
    send_stream(7, 2045, 1, 1'b0, 0, "R6 2047 bytes");
    send_stream(7, 2046, 1, 1'b0, 0, "R6 2048 bytes");
    fcs_mode = 2'd2;
    send_stream(8, 3000, 2, 1'b0, 0, "R6 3004 bytes");

    // R7 then R10: abort mid-frame, next frame on the same connection is fresh
    fcs_mode = 2'd1;
    send_abort(5, 3, "R7 abort mid-frame");
    send_stream(5, 4, 1, 1'b0, 0, "R10 after abort");
    send_abort(6, 0, "R7 abort first byte");
    send_stream(6, 1, 1, 1'b0, 0, "R10 short after abort");

    // R8: leftover bits on the final byte
    send_stream(10, 6, 1, 1'b0, 3, "R8 octet error");
    send_stream(10, 6, 1, 1'b0, 0, "R10 aligned after octet error");

    // R9: interleaved random traffic, dense then spread
    run_random(1, 4, 80);
    run_random(2, 16, 80);
    run_random(0, 3, 30);

    repeat (6) idle();
    chk(due_q.size() == 0, "R1", "headers still outstanding", 32'(due_q.size()), 32'h0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1500us;
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog expired: actual=%0d expected=done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule